// File: doc/BRIEF.md
# Dual Down-Counting Timer with Masked Interrupt

This block holds two independent down-counters behind a word-addressed 32-bit register port that uses a single write strobe and a combinational read. Each counter has three registers: a reload value, a control word and a readback of the live count. The control word holds an operation field and a clock-source select. The operation field loads the counter, freezes it, or lets it run. The select field picks one of four tick-enable inputs, or no tick at all.

A running counter counts selected ticks down and reloads itself when it expires, so it fires periodically. Each expiry latches a status bit. Software masks these bits, reads them raw or masked, and clears them by writing ones to an acknowledge location. One level-sensitive interrupt line is high while any unmasked status bit is set.

Top module: `dual_tick_timer`

## Requirements
- R1: Control bits [1:0] select the operation. 0 copies the reload value into the counter and leaves the run state unchanged. 1 stops the counter. 2 lets it run. 3 changes nothing. The result is visible from the cycle after the write.
- R2: Control bits [4:2] select the tick source. Code 4+k (k = 0..3) takes tick_src[k]. Codes 0 to 3 give no ticks, so the counter never moves.
- R3: While running, each selected tick lowers the counter by one. A tick that finds the counter at 1 or 0 is an expiry: the counter takes the reload value instead of decrementing, so a reload value N gives one expiry every N ticks.
- R4: An expiry of timer 0 sets raw status bit 0, and an expiry of timer 1 sets bit 1. The bit is readable in the cycle after the tick.
- R5: A write to offset 0x4C clears every raw status bit written as 1 and leaves the others alone. An expiry in the same cycle wins, so its bit stays set. Reading 0x4C returns 0.
- R6: Offset 0x54 reads raw status AND mask. irq is high exactly when that value is nonzero, with no delay beyond the register update.
- R7: Writing a reload register never changes the counter.
- R8: Reset (active-low, asynchronous) stops both counters and zeroes the counters, reload values, control words, raw status and mask, so irq is low.
- R9: Word offsets are: timer 0 reload 0x00, count 0x04, control 0x08; timer 1 reload 0x10, count 0x14, control 0x18; mask 0x48; acknowledge 0x4C; raw status 0x50; masked status 0x54. Count offsets return the live counter. Unmapped offsets read 0. Writes to unmapped, count and status offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | AW | Byte offset of the register word |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr, combinational |
| tick_src | input | 4 | Tick enables for source codes 4 to 7 |
| irq | output | 1 | Level interrupt, any masked status bit set |

## Verification
Every register write and every tick is registered once, so its effect is due at the clock edge that ends the cycle in which it was driven. Read data and irq follow combinationally from the registers, with no added delay. The bench drives each stimulus for one full cycle starting at a falling edge. It then moves the address at the next falling edge and compares one time unit later, so each comparison sees exactly one edge's worth of change. The same-cycle cases, an acknowledge that meets an expiry and a control write that meets a tick, are driven in one cycle and checked in the next.

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [3:0]    tick_src,
  output logic          irq
);
  localparam int OPW  = 2;
  localparam int SELW = 3;
  localparam int CW   = OPW + SELW;

  localparam logic [AW-1:0] A_DIV0 = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT0 = AW'(8'h04);
  localparam logic [AW-1:0] A_CTL0 = AW'(8'h08);
  localparam logic [AW-1:0] A_DIV1 = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT1 = AW'(8'h14);
  localparam logic [AW-1:0] A_CTL1 = AW'(8'h18);
  localparam logic [AW-1:0] A_MASK = AW'(8'h48);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h4C);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h50);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h54);

  logic [DW-1:0] div_q [2];
  logic [DW-1:0] cnt_q [2];
  logic [CW-1:0] ctrl_q [2];
  logic [1:0]    run_q, raw_q, mask_q;
  logic [1:0]    wr_div, wr_ctl, tick_en, hit, ack;

  assign wr_div[0] = wr_en && addr == A_DIV0;
  assign wr_div[1] = wr_en && addr == A_DIV1;
  assign wr_ctl[0] = wr_en && addr == A_CTL0;
  assign wr_ctl[1] = wr_en && addr == A_CTL1;
  assign ack       = (wr_en && addr == A_ACK) ? wdata[1:0] : 2'b00;

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    logic [SELW-1:0] sel;
    assign sel        = ctrl_q[g][CW-1:OPW];
    assign tick_en[g] = run_q[g] && sel[SELW-1] && tick_src[sel[1:0]];
    assign hit[g]     = tick_en[g] && (cnt_q[g] <= DW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        div_q[t]  <= '0;
        cnt_q[t]  <= '0;
        ctrl_q[t] <= '0;
      end
      run_q  <= '0;
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (wr_div[t]) div_q[t] <= wdata;
        if (wr_ctl[t]) begin
          ctrl_q[t] <= wdata[CW-1:0];
          case (wdata[OPW-1:0])
            2'd1:    run_q[t] <= 1'b0;
            2'd2:    run_q[t] <= 1'b1;
            default: ;
          endcase
        end
        if (wr_ctl[t] && wdata[OPW-1:0] == 2'd0)
          cnt_q[t] <= div_q[t];
        else if (tick_en[t])
          cnt_q[t] <= hit[t] ? div_q[t] : cnt_q[t] - DW'(1);
      end
      if (wr_en && addr == A_MASK) mask_q <= wdata[1:0];
      raw_q <= (raw_q & ~ack) | hit;
    end
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    case (addr)
      A_DIV0:  rdata = div_q[0];
      A_CNT0:  rdata = cnt_q[0];
      A_CTL0:  rdata = DW'(ctrl_q[0]);
      A_DIV1:  rdata = div_q[1];
      A_CNT1:  rdata = cnt_q[1];
      A_CTL1:  rdata = DW'(ctrl_q[1]);
      A_MASK:  rdata = DW'(mask_q);
      A_RAW:   rdata = DW'(raw_q);
      A_MSK:   rdata = DW'(raw_q & mask_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_tick_timer_chk.sv
module dual_tick_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic [1:0]    raw,
  input logic [1:0]    hit,
  input logic [1:0]    run,
  input logic [DW-1:0] cnt0,
  input logic [DW-1:0] div0
);
  logic wr_ctl0;
  assign wr_ctl0 = wr_en && addr == AW'(8'h08);

  p_stopped_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !wr_ctl0) |=> $stable(cnt0));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !wr_ctl0) |=> cnt0 == $past(div0));

  p_hit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> raw[0]);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h4C) && wdata[0] && !hit[0]) |=> !raw[0]);

  p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h48) && wdata[1:0] == 2'b00) |=> !irq);

  p_div_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h00) && !run[0]) |=> $stable(cnt0));

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && raw == 2'b00));
endmodule

bind dual_tick_timer dual_tick_timer_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .raw(raw_q), .hit(hit), .run(run_q),
  .cnt0(cnt_q[0]), .div0(div_q[0])
);

// File: tb/dual_tick_timer_tb_top.sv
module dual_tick_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  tick_src = '0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_src(tick_src), .irq(irq));

  // kind: 0 write, 1 read and compare (data, irq), 2 tick one cycle (data[3:0])
  // fields: kind[46:45] req[44:41] addr[40:33] data[32:1] irq[0]
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 4'd7, 8'h00, 32'd3, 1'b0},
    {2'd1, 4'd7, 8'h04, 32'd0, 1'b0},          // R7 reload write leaves counter
    {2'd0, 4'd1, 8'h08, 32'h00, 1'b0},
    {2'd1, 4'd1, 8'h04, 32'd3, 1'b0},          // R1 load
    {2'd0, 4'd1, 8'h08, 32'h12, 1'b0},
    {2'd2, 4'd2, 8'h00, 32'h2, 1'b0},
    {2'd1, 4'd2, 8'h04, 32'd3, 1'b0},          // R2 unselected source
    {2'd2, 4'd3, 8'h00, 32'h1, 1'b0},
    {2'd1, 4'd3, 8'h04, 32'd2, 1'b0},          // R3 decrement
    {2'd2, 4'd3, 8'h00, 32'h1, 1'b0},
    {2'd2, 4'd3, 8'h00, 32'h1, 1'b0},
    {2'd1, 4'd4, 8'h50, 32'd1, 1'b0},          // R4 bit 0
    {2'd1, 4'd3, 8'h04, 32'd3, 1'b0},          // R3 reload
    {2'd1, 4'd6, 8'h54, 32'd0, 1'b0},
    {2'd0, 4'd6, 8'h48, 32'd1, 1'b0},
    {2'd1, 4'd6, 8'h54, 32'd1, 1'b1},          // R6
    {2'd0, 4'd5, 8'h4C, 32'd2, 1'b0},
    {2'd1, 4'd5, 8'h50, 32'd1, 1'b1},          // R5 other bit kept
    {2'd0, 4'd5, 8'h4C, 32'd1, 1'b0},
    {2'd1, 4'd5, 8'h50, 32'd0, 1'b0},          // R5 cleared
    {2'd1, 4'd5, 8'h4C, 32'd0, 1'b0},
    {2'd0, 4'd1, 8'h08, 32'h11, 1'b0},
    {2'd2, 4'd1, 8'h00, 32'h1, 1'b0},
    {2'd1, 4'd1, 8'h04, 32'd3, 1'b0},          // R1 hold
    {2'd0, 4'd9, 8'h10, 32'd2, 1'b0},
    {2'd0, 4'd9, 8'h18, 32'h00, 1'b0},
    {2'd0, 4'd9, 8'h18, 32'h1E, 1'b0},
    {2'd2, 4'd2, 8'h00, 32'h8, 1'b0},
    {2'd1, 4'd2, 8'h14, 32'd1, 1'b0},          // R2 source 3
    {2'd2, 4'd4, 8'h00, 32'h8, 1'b0},
    {2'd1, 4'd4, 8'h50, 32'd2, 1'b0},          // R4 bit 1
    {2'd1, 4'd3, 8'h14, 32'd2, 1'b0},
    {2'd1, 4'd9, 8'h18, 32'h1E, 1'b0},
    {2'd1, 4'd9, 8'h10, 32'd2, 1'b0},
    {2'd0, 4'd9, 8'h20, 32'hFFFFFFFF, 1'b0},
    {2'd1, 4'd9, 8'h20, 32'd0, 1'b0},          // R9 unmapped
    {2'd0, 4'd9, 8'h50, 32'd0, 1'b0},
    {2'd1, 4'd9, 8'h50, 32'd2, 1'b0},          // R9 status read-only
    {2'd0, 4'd9, 8'h14, 32'd7, 1'b0},
    {2'd1, 4'd9, 8'h14, 32'd2, 1'b0},          // R9 count read-only
    {2'd0, 4'd2, 8'h18, 32'h02, 1'b0},
    {2'd2, 4'd2, 8'h00, 32'hF, 1'b0},
    {2'd1, 4'd2, 8'h14, 32'd2, 1'b0},          // R2 code 0 no advance
    {2'd0, 4'd6, 8'h48, 32'd2, 1'b0},
    {2'd1, 4'd6, 8'h48, 32'd2, 1'b1},          // R6 mask read, irq
    {2'd1, 4'd9, 8'h08, 32'h11, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] tk);
    wr_en = 1'b1; addr = a; wdata = d; tick_src = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_src = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] e, input logic ei);
    addr = a;
    #1;
    chk(req, rdata, e);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, ei});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    rd("R8", 8'h04, 0, 0);
    rd("R8", 8'h08, 0, 0);
    rd("R8", 8'h48, 0, 0);
    rd("R8", 8'h50, 0, 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VEC[i][44:41], i);
      case (VEC[i][46:45])
        2'd0: wr(VEC[i][40:33], VEC[i][32:1], 4'h0);
        2'd1: rd(rq, VEC[i][40:33], VEC[i][32:1], VEC[i][0]);
        default: begin
          tick_src = VEC[i][4:1];
          @(negedge clk);
          tick_src = '0;
        end
      endcase
    end

    // R3 reload 1 gives an expiry every tick; R5 expiry beats same-cycle ack
    wr(8'h4C, 32'd3, 4'h0);
    wr(8'h00, 32'd1, 4'h0);
    wr(8'h08, 32'h10, 4'h0);
    rd("R1 load under hold", 8'h04, 1, 0);
    wr(8'h08, 32'h12, 4'h0);
    wr(8'h4C, 32'd1, 4'h1);
    rd("R5 expiry wins", 8'h50, 1, 0);
    rd("R3 period one", 8'h04, 1, 0);
    wr(8'h08, 32'h13, 4'h0);
    wr(8'h00, 32'd9, 4'h1);
    rd("R1 op3 keeps running", 8'h04, 1, 0);

    // R8 reset mid-operation
    wr(8'h48, 32'd3, 4'h0);
    rd("R6 raw masked", 8'h54, 1, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick_src = 4'hF;
    @(negedge clk);
    tick_src = '0;
    rd("R8 counter", 8'h04, 0, 0);
    rd("R8 raw", 8'h50, 0, 0);
    rd("R8 mask", 8'h48, 0, 0);
    rd("R8 reload", 8'h00, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule